// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block turns single requests from a synchronous host into the strobe sequences of a 16-bit asynchronous DRAM with extended data output. The host offers a 22-bit word address, write data, two byte enables and a read/write flag under a valid/ready handshake. The controller places the row half of the address on a shared address bus and lowers the row strobe. It then places the column half and lowers one or both column strobes, one strobe for each byte lane. Every timing minimum is a parameter counted in clock cycles. Each nanosecond figure is rounded up to whole periods.

After a column the row stays open. If the next request targets the same row, no refresh is pending and the row has not been open too long, only the column strobes toggle (page mode). Otherwise the row strobe is released and precharge runs. An external refresh-pending input blocks new accesses and ends an open page.

The controller moves through five states. IDLE accepts a request and goes to ACTIVATE. ACTIVATE drives the row with the row strobe low for T_RCD cycles, then goes to COLUMN. COLUMN drives the column and the selected column strobes, then goes to PAGE_GAP. PAGE_GAP holds the column strobes high. From there it either accepts a same-row request and returns to COLUMN, or closes to PRECHARGE. PRECHARGE holds the row strobe high for T_RP cycles, then returns to IDLE.

Top module: `edo_ctrl`

## Requirements
- R1: After reset, the row and column strobes, the write strobe and the output-enable strobe are high, the data bus is not driven, rsp_valid is low and req_ready is high while ref_pending is low.
- R2: Address bit 21 down to 10 is the row and appears on mem_addr in the cycle the row strobe falls. Bits 9 down to 0 are the column and appear zero-extended on mem_addr in the cycle a column strobe falls.
- R3: Byte enable bit 0 selects the lower lane and lowers mem_lcas_n. Bit 1 selects the upper lane and lowers mem_ucas_n. A lane whose enable is 0 keeps its strobe high. A read holds mem_oe_n low and mem_we_n high while the column strobes are low.
- R4: A write holds mem_we_n low from the cycle the column strobes fall and for as long as they are low, with mem_oe_n high. mem_dq_oe is high only during the column-strobe-low cycles of a write, and it carries the request's data.
- R5: Read data is sampled at the clock edge that comes CAS_CYC = max(T_CAC, T_AA, T_CAS_MIN) cycles after the column strobes fall. rsp_valid is then high for exactly one cycle with that word.
- R6: A same-row request that is pending at the end of the column-strobe-high gap is served without the row strobe rising. The column strobes stay high for at least T_CP cycles between columns.
- R7: When no qualifying request is pending, the row strobe rises. It stays high for at least T_RP cycles before it falls again.
- R8: While ref_pending is high, req_ready is low, no new row is opened and an open page is closed at its next decision point.
- R9: The row strobe stays low for at most T_RAS_MAX cycles. A longer same-row stream is split across several row openings.
- R10: The column strobes fall only while the row strobe is low, at least T_RCD cycles after it fell. The row strobe stays low for at least T_RAS_MIN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address (row bits 21:10, column bits 9:0) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper lane |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Captured read word |
| ref_pending | input | 1 | Refresh wants the memory; hold off accesses |
| mem_addr | output | 12 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_ucas_n | output | 1 | Upper-lane column strobe, active low |
| mem_lcas_n | output | 1 | Lower-lane column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The case that is hardest to reach from the ports is the forced page close at the open-row time limit. Only an uninterrupted stream of same-row requests gets there, and each request must arrive at exactly the decision point of the gap state. The bench shrinks T_RAS_MAX to 24 cycles and issues eight back-to-back same-row requests through a handshake task that presents the next request as soon as the previous one is taken. It then counts row openings. The memory model drives a garbage word until the access count has elapsed after each column strobe falls, so a capture even one cycle early returns wrong data.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVATE,
        ST_COLUMN,
        ST_PAGE_GAP,
        ST_PRECHARGE
    } edo_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/edo_cnt.sv
// Saturating up-counter with synchronous clear.
module edo_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/edo_capture.sv
// Read-data register with a one-cycle valid pulse.
module edo_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grab,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= grab;
            if (grab)
                dout <= din;
        end
    end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int T_RCD     = 2,     // row strobe to column strobe
    parameter int T_RAS_MIN = 7,     // minimum row strobe low time
    parameter int T_CAS_MIN = 1,     // minimum column strobe low time
    parameter int T_CP      = 1,     // column strobe high gap
    parameter int T_RP      = 4,     // row precharge
    parameter int T_CAC     = 2,     // access from column strobe
    parameter int T_AA      = 4,     // access from column address
    parameter int T_RAS_MAX = 25000  // maximum row strobe low time
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_we,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [1:0]              req_be,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    input  logic                    ref_pending,
    output logic [ROW_W-1:0]        mem_addr,
    output logic                    mem_ras_n,
    output logic                    mem_ucas_n,
    output logic                    mem_lcas_n,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic [DATA_W-1:0]       mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [DATA_W-1:0]       mem_dq_in
);
    localparam int ADDR_W    = ROW_W + COL_W;
    localparam int CAS_CYC   = max3(T_CAC, T_AA, T_CAS_MIN);
    localparam int STEP_MAX  = max3(max3(T_RCD, CAS_CYC, T_CP), T_RP, 1);
    localparam int CNT_W     = $clog2(STEP_MAX + 1);
    localparam int AGE_W     = $clog2(T_RAS_MAX + 2);
    localparam int AGE_LIMIT = T_RAS_MAX - CAS_CYC - T_CP - 1;

    localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] COL_LAST = CNT_W'(CAS_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(T_CP - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(T_RP - 1);
    localparam logic [AGE_W-1:0] AGE_LIM  = AGE_W'(AGE_LIMIT);
    localparam logic [AGE_W-1:0] RAS_OK   = AGE_W'(T_RAS_MIN - 1);

    edo_state_e state, nstate;

    logic [CNT_W-1:0]  step;
    logic [AGE_W-1:0]  age;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              we_q;
    logic [1:0]        be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept, row_hit, gap_done, ras_ok, page_ok, grab;
    logic              ras_c;

    // step counts cycles inside a state; age counts row-open cycles
    edo_cnt #(.W(CNT_W)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(state != nstate), .cnt(step));

    edo_cnt #(.W(AGE_W)) u_age (
        .clk(clk), .rst_n(rst_n), .clr(ras_c), .cnt(age));

    assign row_hit  = (req_addr[ADDR_W-1:COL_W] == row_q);
    assign gap_done = (step >= GAP_LAST);
    assign ras_ok   = (age >= RAS_OK);
    assign page_ok  = (state == ST_PAGE_GAP) && gap_done && row_hit &&
                      !ref_pending && (age <= AGE_LIM);
    assign req_ready = ((state == ST_IDLE) && !ref_pending) || page_ok;
    assign accept    = req_valid && req_ready;
    assign grab      = (state == ST_COLUMN) && (step == COL_LAST) && !we_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:      if (accept) nstate = ST_ACTIVATE;
            ST_ACTIVATE:  if (step == ACT_LAST) nstate = ST_COLUMN;
            ST_COLUMN:    if (step == COL_LAST) nstate = ST_PAGE_GAP;
            ST_PAGE_GAP: begin
                if (accept)
                    nstate = ST_COLUMN;
                else if (gap_done && ras_ok)
                    nstate = ST_PRECHARGE;
            end
            ST_PRECHARGE: if (step == PRE_LAST) nstate = ST_IDLE;
            default:      nstate = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            row_q   <= req_addr[ADDR_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            we_q    <= req_we;
            be_q    <= req_be;
            wdata_q <= req_wdata;
        end
    end

    // strobe decode
    always_comb begin
        ras_c      = 1'b1;
        mem_ucas_n = 1'b1;
        mem_lcas_n = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_addr   = row_q;
        unique case (state)
            ST_ACTIVATE: begin
                ras_c    = 1'b0;
                mem_we_n = !we_q;
            end
            ST_COLUMN: begin
                ras_c      = 1'b0;
                mem_addr   = ROW_W'(col_q);
                mem_ucas_n = !be_q[1];
                mem_lcas_n = !be_q[0];
                mem_we_n   = !we_q;
                mem_oe_n   = we_q;
                mem_dq_oe  = we_q;
            end
            ST_PAGE_GAP: begin
                ras_c    = 1'b0;
                mem_addr = ROW_W'(col_q);
            end
            default: ;
        endcase
    end

    assign mem_ras_n  = ras_c;
    assign mem_dq_out = wdata_q;

    edo_capture #(.W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .grab(grab), .din(mem_dq_in),
        .dout(rsp_rdata), .valid(rsp_valid));

endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int T_RP      = 4,
    parameter int T_RAS_MAX = 25000
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic ref_pending,
    input logic rsp_valid,
    input logic mem_ras_n,
    input logic mem_ucas_n,
    input logic mem_lcas_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_dq_oe
);
    logic [31:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 32'(T_RP);
            lo_cnt <= '0;
        end else begin
            hi_cnt <= mem_ras_n ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 32'd1) : '0;
            lo_cnt <= mem_ras_n ? '0 : lo_cnt + 32'd1;
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ucas_n || !mem_lcas_n) |-> !mem_ras_n);                          // R10
    AST_DQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && (!mem_ucas_n || !mem_lcas_n)));            // R4
    AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);                                               // R3
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                             // R5
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pending |-> !req_ready);                                           // R8
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (hi_cnt >= 32'(T_RP)));                           // R7
    AST_RAS_OPEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= 32'(T_RAS_MAX));                                             // R9
endmodule

bind edo_ctrl edo_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_edo_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_pending(ref_pending),
    .rsp_valid(rsp_valid), .mem_ras_n(mem_ras_n), .mem_ucas_n(mem_ucas_n),
    .mem_lcas_n(mem_lcas_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_oe(mem_dq_oe));

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
    localparam int P_RAS_MAX = 24;
    localparam int P_RCD = 2, P_RP = 4, P_CP = 1, P_ACC = 4, P_RAS_MIN = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, ref_pending = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0, mem_dq_in = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid, mem_ras_n, mem_ucas_n, mem_lcas_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_out;
    logic [11:0] mem_addr;

    always #4 clk = ~clk;

    edo_ctrl #(.T_RAS_MAX(P_RAS_MAX)) u_edo_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_pending(ref_pending),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_ucas_n(mem_ucas_n),
        .mem_lcas_n(mem_lcas_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    typedef struct { logic we; logic [21:0] addr; logic [15:0] data; logic [1:0] be; } acc_t;
    typedef struct { logic [15:0] data; logic [1:0] be; } rsp_t;
    acc_t        acc_q[$];
    rsp_t        rsp_q[$];
    logic [15:0] shadow[int];
    logic [15:0] dram[int];
    int checks = 0, fails = 0, ras_falls = 0;

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // handshake: called at a negedge, returns at the negedge after acceptance
    task automatic issue(input logic we, input logic [21:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        bit rdy;
        acc_t e;
        logic [15:0] old, m;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        do begin
            #1 rdy = req_ready;
            @(posedge clk);
            if (!rdy) @(negedge clk);
        end while (!rdy);
        e.we = we; e.addr = a; e.data = d; e.be = be;
        acc_q.push_back(e);
        m   = lane_mask(be);
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        if (we) shadow[int'(a)] = (old & ~m) | (d & m);
        else    rsp_q.push_back('{data: old, be: be});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    // protocol monitor and memory model, sampled at negedges
    logic        prev_ras = 1'b1, prev_cas = 1'b0, prev_rsp = 1'b0, first_cas = 1'b0;
    int          hi_run = 100, lo_run = 0, since_ras = 0, gap_run = 0, acc_k = 0;
    logic [11:0] cur_row = '0;
    logic [15:0] model_word = '0;

    always @(negedge clk) begin
        logic cas_low;
        acc_t e;
        rsp_t r;
        logic [15:0] m;
        int key;
        if (rst_n) begin
            cas_low = !mem_ucas_n || !mem_lcas_n;
            if (prev_ras && !mem_ras_n) begin
                check(hi_run >= P_RP, "R7 precharge", 32'(hi_run), 32'(P_RP));
                if (acc_q.size() > 0)
                    check(mem_addr == acc_q[0].addr[21:10], "R2 row", 32'(mem_addr),
                          32'(acc_q[0].addr[21:10]));
                cur_row = mem_addr; ras_falls++; since_ras = 0; first_cas = 1'b1;
            end else if (!mem_ras_n) since_ras++;
            if (!prev_ras && mem_ras_n) begin
                check(lo_run >= P_RAS_MIN, "R10 ras min", 32'(lo_run), 32'(P_RAS_MIN));
                check(lo_run <= P_RAS_MAX, "R9 ras max", 32'(lo_run), 32'(P_RAS_MAX));
            end
            check(!(cas_low && mem_ras_n), "R10 cas under ras", 32'(mem_ras_n), 32'd0);
            check(!mem_dq_oe || (!mem_we_n && cas_low), "R4 dq drive", 32'(mem_dq_oe), 32'd0);
            if (cas_low && !prev_cas) begin
                if (acc_q.size() == 0) check(1'b0, "R2 unexpected column", 0, 0);
                else begin
                    e = acc_q.pop_front();
                    check(mem_addr == 12'(e.addr[9:0]), "R2 column", 32'(mem_addr),
                          32'(e.addr[9:0]));
                    check(cur_row == e.addr[21:10], "R6 open row", 32'(cur_row),
                          32'(e.addr[21:10]));
                    check({mem_ucas_n, mem_lcas_n} == ~e.be, "R3 lanes",
                          32'({mem_ucas_n, mem_lcas_n}), 32'(~e.be));
                    check(mem_we_n == !e.we, "R4 we", 32'(mem_we_n), 32'(!e.we));
                    check(mem_oe_n == e.we, "R3 oe", 32'(mem_oe_n), 32'(e.we));
                    if (first_cas)
                        check(since_ras >= P_RCD, "R10 rcd", 32'(since_ras), 32'(P_RCD));
                    else
                        check(gap_run >= P_CP, "R6 cas gap", 32'(gap_run), 32'(P_CP));
                    key = int'({cur_row, mem_addr[9:0]});
                    m = lane_mask(~{mem_ucas_n, mem_lcas_n});
                    if (!mem_we_n) begin
                        check(mem_dq_oe && ((mem_dq_out & m) == (e.data & m)), "R4 wdata",
                              32'(mem_dq_out & m), 32'(e.data & m));
                        dram[key] = ((dram.exists(key) ? dram[key] : 16'h0) & ~m) |
                                    (mem_dq_out & m);
                    end else
                        model_word = dram.exists(key) ? dram[key] : 16'h0;
                end
                first_cas = 1'b0; gap_run = 0; acc_k = 1;
            end else if (acc_k > 0) acc_k++;
            if (!mem_ras_n && !cas_low) gap_run++;
            if (rsp_valid) begin
                check(!prev_rsp, "R5 pulse", 32'(prev_rsp), 32'd0);
                if (rsp_q.size() == 0) check(1'b0, "R5 unexpected rsp", 0, 0);
                else begin
                    r = rsp_q.pop_front();
                    m = lane_mask(r.be);
                    check((rsp_rdata & m) == (r.data & m), "R5 rdata",
                          32'(rsp_rdata & m), 32'(r.data & m));
                end
            end
            mem_dq_in = (acc_k >= P_ACC) ? model_word : 16'hBAD0 ^ 16'(acc_k);
            hi_run   = mem_ras_n ? hi_run + 1 : 0;
            lo_run   = mem_ras_n ? 0 : lo_run + 1;
            prev_ras = mem_ras_n; prev_cas = cas_low; prev_rsp = rsp_valid;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_oe_n} == 5'b11111,
              "R1 strobes", 32'({mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_oe_n}), 32'h1f);
        check(!mem_dq_oe && !rsp_valid && req_ready, "R1 idle outputs",
              32'({mem_dq_oe, rsp_valid, req_ready}), 32'b001);

        // R2 R4 R5: single write then read back
        issue(1'b1, 22'h12345, 16'hA55A, 2'b11); settle();
        issue(1'b0, 22'h12345, 16'h0000, 2'b11); settle();

        // R3 byte lanes: separate lane writes, word and byte reads
        issue(1'b1, 22'h00407, 16'h11C3, 2'b01); settle();
        issue(1'b1, 22'h00407, 16'h7E22, 2'b10); settle();
        issue(1'b0, 22'h00407, 16'h0000, 2'b11); settle();
        issue(1'b0, 22'h00407, 16'h0000, 2'b10); settle();

        // R6 page bursts: four writes then four reads in one row
        base = ras_falls;
        for (int i = 0; i < 4; i++) issue(1'b1, {12'h2A5, 10'(i * 3)}, 16'(16'h3000 + i * 17), 2'b11);
        settle();
        check(ras_falls - base == 1, "R6 write burst openings", 32'(ras_falls - base), 1);
        base = ras_falls;
        for (int i = 0; i < 4; i++) issue(1'b0, {12'h2A5, 10'(i * 3)}, 16'h0, 2'b11);
        settle();
        check(ras_falls - base == 1, "R6 read burst openings", 32'(ras_falls - base), 1);

        // R7 row change closes the page
        base = ras_falls;
        issue(1'b0, {12'h2A5, 10'd3}, 16'h0, 2'b11);
        issue(1'b0, {12'h2A6, 10'd3}, 16'h0, 2'b11);
        settle();
        check(ras_falls - base == 2, "R7 row change openings", 32'(ras_falls - base), 2);

        // R2 address extremes
        issue(1'b1, 22'h3FFFFF, 16'hC0DE, 2'b11); settle();
        issue(1'b0, 22'h3FFFFF, 16'h0, 2'b11); settle();

        // R8 refresh hold while idle
        base = ras_falls;
        ref_pending = 1'b1;
        fork
            issue(1'b0, 22'h12345, 16'h0, 2'b11);
            begin
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    check(!req_ready && mem_ras_n, "R8 idle hold",
                          32'({req_ready, mem_ras_n}), 32'b01);
                end
                ref_pending = 1'b0;
            end
        join
        settle();
        check(ras_falls - base == 1, "R8 held access served", 32'(ras_falls - base), 1);

        // R8 refresh ends an open page
        base = ras_falls;
        issue(1'b0, {12'h2A5, 10'd0}, 16'h0, 2'b11);
        ref_pending = 1'b1;
        fork
            issue(1'b0, {12'h2A5, 10'd6}, 16'h0, 2'b11);
            begin repeat (14) @(negedge clk); ref_pending = 1'b0; end
        join
        settle();
        check(ras_falls - base == 2, "R8 page closed by refresh", 32'(ras_falls - base), 2);

        // R9 long same-row stream is split by the open-row limit
        base = ras_falls;
        for (int i = 0; i < 8; i++) issue(1'b0, {12'h2A5, 10'(i)}, 16'h0, 2'b11);
        settle();
        check(ras_falls - base == 2, "R9 stream split", 32'(ras_falls - base), 2);

        check(acc_q.size() == 0 && rsp_q.size() == 0, "R5 all responses drained",
              32'(acc_q.size() + rsp_q.size()), 0);
        finish_run();
    end
endmodule